// File: doc/BRIEF.md
# EEPROM Page-Write Controller

This block is a clocked model of the write engine inside a byte-wide parallel EEPROM core. The chip-enable, output-enable and write-enable strobes come in asynchronously. A synchronizer samples them, together with the address and data, on the system clock. Each qualified write strobe loads one byte into a page buffer. The page is chosen by the first byte of a burst, and the low address bits select the byte within the page.

The end of every write strobe restarts a byte-load window. The window is frozen while a strobe is active, so a burst of 1 to `PAGE_BYTES` bytes can be gathered. Once the window runs out with no new strobe, a self-timed programming phase of fixed length commits every loaded byte to the behavioural array and then empties the buffer.

During programming, a read returns a status word instead of array data. The top bit is the inverse of the top bit of the last byte loaded. The next bit flips on every read. Array data returns once the phase ends. The data bus is split into `din` and `dout`, and `dout_en` drives the pad buffer at chip level.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `dout_en` is 0, `dout` is 0, and every array byte holds `ERASE_VAL` (0xFF by default).
- R2: A read (chip-enable low, output-enable low, write-enable high) drives `dout_en` high with the array byte at `addr`. With chip-enable high, with output-enable and write-enable both high, or with both low, `dout_en` is 0 and `dout` is 0.
- R3: A write strobe exists only while chip-enable and write-enable are both low and output-enable is high. Strobing write-enable with output-enable low changes nothing.
- R4: A write may be steered by write-enable (chip-enable held low) or by chip-enable (write-enable held low). Address and data are taken as sampled at the end of the strobe.
- R5: A strobe active for fewer than `MIN_LOW_CYC` synchronized clocks is ignored. A strobe of exactly `MIN_LOW_CYC` clocks is accepted.
- R6: The end of every accepted strobe reloads the load window to `LOAD_CYC` clocks. The window is held while a strobe is active. Programming starts only after the window runs out with no strobe active.
- R7: The page is `addr[ADDR_W-1:6]` of the first byte of a burst. Later bytes use only their offset `addr[5:0]`, and their page field is ignored.
- R8: Only offsets loaded in the burst change in the array. A repeated load to one offset keeps the last value. One to 64 bytes can be loaded in a burst.
- R9: Programming lasts `PROG_CYC` clocks. Afterwards, reads return the committed bytes, and the buffer is empty, so the next burst starts afresh.
- R10: A read during programming returns bit 7 equal to the inverse of bit 7 of the last loaded byte, and bits 5..0 zero. Bit 6 is 1 on the first read of the phase and inverts on each later read.
- R11: A write strobe that ends during programming is ignored. It loads nothing, restarts no window and changes no status bit.
- R12: Before programming starts, reads return the array's old contents, not the buffered bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W | Byte address: page in upper bits, offset in bits 5..0 |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or programming status |
| dout_en | output | 1 | High while a read drives the bus |

## Verification
A wrong buffer or window state shows up at the ports in one of two ways. It either shows as array bytes that are missing, misplaced or stale, once the programming phase has ended, or as a status word that appears too early, too late or never. A read placed a few clocks after the last strobe tells a window that expired too early from a correct one. A pair of reads placed well inside the phase catches a corrupted last-byte bit or a toggle that does not alternate. Reads of every offset of the page after the phase catch commits that leaked to unloaded offsets or to the wrong page, within one programming period.

// File: rtl/epw_pkg.sv
package epw_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOAD = 2'd1,
      PH_PROG = 2'd2
   } phase_t;
endpackage

// File: rtl/epw_strobe_sync.sv
module epw_strobe_sync #(
   parameter int AW          = 11,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LOW_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic          wr_act,
   output logic          rd_act,
   output logic          wr_done,
   output logic          rd_start,
   output logic [AW-1:0] addr_s,
   output logic [DW-1:0] din_s
);
   localparam int BUS_W = 3 + AW + DW;
   localparam logic [BUS_W-1:0] RST_V = {3'b111, {(AW + DW){1'b0}}};

   logic [SYNC_STAGES-1:0][BUS_W-1:0] stage_q;
   logic [BUS_W-1:0] tail;
   logic ce_s, oe_s, we_s;
   logic wr_q, rd_q, long_enough;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_stages
         $error("SYNC_STAGES must be at least 1");
      end
      if (MIN_LOW_CYC < 1) begin : g_bad_min
         $error("MIN_LOW_CYC must be at least 1");
      end

      if (SYNC_STAGES == 1) begin : g_one_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= RST_V;
            else        stage_q <= {ce_n, oe_n, we_n, addr, din};
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= {SYNC_STAGES{RST_V}};
            else        stage_q <= {stage_q[SYNC_STAGES-2:0], {ce_n, oe_n, we_n, addr, din}};
         end
      end
   endgenerate

   assign tail   = stage_q[SYNC_STAGES-1];
   assign ce_s   = tail[BUS_W-1];
   assign oe_s   = tail[BUS_W-2];
   assign we_s   = tail[BUS_W-3];
   assign addr_s = tail[AW+DW-1:DW];
   assign din_s  = tail[DW-1:0];

   assign wr_act = ~ce_s & ~we_s & oe_s;
   assign rd_act = ~ce_s & ~oe_s & we_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= 1'b0;
         rd_q <= 1'b0;
      end else begin
         wr_q <= wr_act;
         rd_q <= rd_act;
      end
   end

   generate
      if (MIN_LOW_CYC == 1) begin : g_no_filter
         assign long_enough = 1'b1;
      end else begin : g_filter
         localparam int LCW = $clog2(MIN_LOW_CYC + 1);
         logic [LCW-1:0] low_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               low_cnt <= '0;
            end else if (wr_act) begin
               if (low_cnt != LCW'(MIN_LOW_CYC)) low_cnt <= low_cnt + 1'b1;
            end else begin
               low_cnt <= '0;
            end
         end
         assign long_enough = (low_cnt == LCW'(MIN_LOW_CYC));
      end
   endgenerate

   assign wr_done  = wr_q & ~wr_act & long_enough;
   assign rd_start = rd_act & ~rd_q;
endmodule

// File: rtl/epw_page_buf.sv
module epw_page_buf #(
   parameter int AW         = 11,
   parameter int DW         = 8,
   parameter int PAGE_BYTES = 64,
   localparam int OFF_W     = $clog2(PAGE_BYTES),
   localparam int PG_W      = AW - OFF_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic                  clear,
   input  logic [AW-1:0]         ld_addr,
   input  logic [DW-1:0]         ld_data,
   input  logic [OFF_W-1:0]      rd_idx,
   output logic [PG_W-1:0]       page,
   output logic [PAGE_BYTES-1:0] valid,
   output logic [DW-1:0]         rd_data,
   output logic                  rd_valid,
   output logic                  last_msb
);
   logic [DW-1:0] bytes [PAGE_BYTES];
   logic [OFF_W-1:0] ld_off;

   assign ld_off = ld_addr[OFF_W-1:0];

   generate
      for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
         logic          v_q;
         logic [DW-1:0] d_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               d_q <= '0;
            end else if (clear) begin
               v_q <= 1'b0;
            end else if (load && ld_off == OFF_W'(i)) begin
               v_q <= 1'b1;
               d_q <= ld_data;
            end
         end
         assign valid[i] = v_q;
         assign bytes[i] = d_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page     <= '0;
         last_msb <= 1'b0;
      end else if (load) begin
         if (valid == '0) page <= ld_addr[AW-1:OFF_W];
         last_msb <= ld_data[DW-1];
      end
   end

   assign rd_data  = bytes[rd_idx];
   assign rd_valid = valid[rd_idx];
endmodule

// File: rtl/epw_sequencer.sv
module epw_sequencer
   import epw_pkg::*;
#(
   parameter int LOAD_CYC   = 10000,
   parameter int PROG_CYC   = 1000000,
   parameter int PAGE_BYTES = 64,
   localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_done,
   input  logic             wr_act,
   output phase_t           phase,
   output logic             accept,
   output logic             prog_start,
   output logic             prog_end,
   output logic             commit_go,
   output logic [OFF_W-1:0] commit_idx
);
   localparam int LW = $clog2(LOAD_CYC + 1);
   localparam int PW = $clog2(PROG_CYC + 1);

   logic [LW-1:0] lcnt;
   logic [PW-1:0] pcnt;
   logic          idx_done;

   generate
      if (LOAD_CYC < 1) begin : g_bad_load
         $error("LOAD_CYC must be at least 1");
      end
      if (PROG_CYC < PAGE_BYTES) begin : g_bad_prog
         $error("PROG_CYC must cover one commit cycle per page byte");
      end
   endgenerate

   assign accept     = wr_done && (phase != PH_PROG);
   assign prog_start = (phase == PH_LOAD) && !wr_done && !wr_act && (lcnt == '0);
   assign prog_end   = (phase == PH_PROG) && (pcnt == '0);
   assign commit_go  = (phase == PH_PROG) && !idx_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         lcnt       <= '0;
         pcnt       <= '0;
         commit_idx <= '0;
         idx_done   <= 1'b0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (wr_done) begin
                  phase <= PH_LOAD;
                  lcnt  <= LW'(LOAD_CYC);
               end
            end
            PH_LOAD: begin
               if (wr_done) begin
                  lcnt <= LW'(LOAD_CYC);
               end else if (!wr_act) begin
                  if (lcnt == '0) begin
                     phase      <= PH_PROG;
                     pcnt       <= PW'(PROG_CYC - 1);
                     commit_idx <= '0;
                     idx_done   <= 1'b0;
                  end else begin
                     lcnt <= lcnt - 1'b1;
                  end
               end
            end
            PH_PROG: begin
               if (pcnt == '0) phase <= PH_IDLE;
               else            pcnt  <= pcnt - 1'b1;
               if (!idx_done) begin
                  if (commit_idx == OFF_W'(PAGE_BYTES - 1)) idx_done   <= 1'b1;
                  else                                      commit_idx <= commit_idx + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/epw_array.sv
module epw_array #(
   parameter int AW                  = 11,
   parameter int DW                  = 8,
   parameter logic [DW-1:0] ERASE_VAL = '1,
   localparam int DEPTH               = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= ERASE_VAL;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
   import epw_pkg::*;
#(
   parameter int ADDR_W                   = 11,
   parameter int DATA_W                   = 8,
   parameter int PAGE_BYTES               = 64,
   parameter int LOAD_CYC                 = 10000,
   parameter int PROG_CYC                 = 1000000,
   parameter int SYNC_STAGES              = 2,
   parameter int MIN_LOW_CYC              = 2,
   parameter logic [DATA_W-1:0] ERASE_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   localparam int OFF_W = $clog2(PAGE_BYTES);
   localparam int PG_W  = ADDR_W - OFF_W;

   generate
      if (DATA_W < 3) begin : g_bad_dw
         $error("DATA_W must be at least 3 for the status word");
      end
      if ((1 << OFF_W) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (PG_W < 1) begin : g_bad_aw
         $error("ADDR_W must exceed the page offset width");
      end
   endgenerate

   logic                  wr_act, rd_act, wr_done, rd_start;
   logic [ADDR_W-1:0]     addr_s;
   logic [DATA_W-1:0]     din_s;
   phase_t                phase;
   logic                  accept, prog_start, prog_end, commit_go;
   logic [OFF_W-1:0]      commit_idx;
   logic [PG_W-1:0]       page;
   logic [PAGE_BYTES-1:0] buf_valid;
   logic [DATA_W-1:0]     buf_byte;
   logic                  buf_byte_v, last_msb;
   logic [DATA_W-1:0]     arr_rdata;
   logic                  arr_we;
   logic                  tog;
   logic [DATA_W-1:0]     status_w;

   epw_strobe_sync #(
      .AW(ADDR_W), .DW(DATA_W), .SYNC_STAGES(SYNC_STAGES), .MIN_LOW_CYC(MIN_LOW_CYC)
   ) i_sync (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .wr_act(wr_act), .rd_act(rd_act),
      .wr_done(wr_done), .rd_start(rd_start), .addr_s(addr_s), .din_s(din_s)
   );

   epw_sequencer #(
      .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC), .PAGE_BYTES(PAGE_BYTES)
   ) i_seq (
      .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .wr_act(wr_act),
      .phase(phase), .accept(accept), .prog_start(prog_start), .prog_end(prog_end),
      .commit_go(commit_go), .commit_idx(commit_idx)
   );

   epw_page_buf #(
      .AW(ADDR_W), .DW(DATA_W), .PAGE_BYTES(PAGE_BYTES)
   ) i_buf (
      .clk(clk), .rst_n(rst_n), .load(accept), .clear(prog_end),
      .ld_addr(addr_s), .ld_data(din_s), .rd_idx(commit_idx),
      .page(page), .valid(buf_valid), .rd_data(buf_byte),
      .rd_valid(buf_byte_v), .last_msb(last_msb)
   );

   assign arr_we = commit_go & buf_byte_v;

   epw_array #(
      .AW(ADDR_W), .DW(DATA_W), .ERASE_VAL(ERASE_VAL)
   ) i_arr (
      .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr({page, commit_idx}),
      .wdata(buf_byte), .raddr(addr_s), .rdata(arr_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            tog <= 1'b0;
      else if (prog_start)                   tog <= 1'b0;
      else if (phase == PH_PROG && rd_start) tog <= ~tog;
   end

   assign status_w = {~last_msb, tog ^ rd_start, {(DATA_W - 2){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout    <= '0;
         dout_en <= 1'b0;
      end else if (rd_act) begin
         dout_en <= 1'b1;
         dout    <= (phase == PH_PROG) ? status_w : arr_rdata;
      end else begin
         dout_en <= 1'b0;
         dout    <= '0;
      end
   end
endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk
   import epw_pkg::*;
#(
   parameter int DW         = 8,
   parameter int PAGE_BYTES = 64
) (
   input logic                  clk,
   input logic                  rst_n,
   input phase_t                phase,
   input logic                  wr_act,
   input logic                  rd_act,
   input logic [PAGE_BYTES-1:0] valid,
   input logic [DW-1:0]         dout,
   input logic                  dout_en
);
   assert_bus_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> dout == '0);

   assert_status_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(phase) == PH_PROG && $past(rd_act)) |-> (dout_en && dout[DW-3:0] == '0));

   assert_prog_after_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PROG && $past(phase) != PH_PROG) |-> ($past(phase) == PH_LOAD && !$past(wr_act)));

   assert_load_has_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_LOAD |-> valid != '0);

   assert_idle_buffer_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_IDLE |-> valid == '0);

   assert_prog_buffer_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PROG && $past(phase) == PH_PROG) |-> $stable(valid));
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(
   .DW(DATA_W), .PAGE_BYTES(PAGE_BYTES)
) i_chk (
   .clk(clk), .rst_n(rst_n), .phase(phase), .wr_act(wr_act), .rd_act(rd_act),
   .valid(buf_valid), .dout(dout), .dout_en(dout_en)
);

// File: tb/test_eeprom_page_writer.sv
`timescale 1ns/1ps
module test_eeprom_page_writer;
   localparam int AW = 11;
   localparam int DW = 8;
   localparam int PB = 64;
   localparam int LC = 30;
   localparam int PC = 80;
   localparam int SETTLE = LC + PC + 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic dout_en;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   logic [7:0] model [0:2047];
   bit         pv [0:63];
   logic [7:0] pd [0:63];
   logic [4:0] ppage;
   bit         pany;
   logic [7:0] plast;
   logic [7:0] rv;
   logic       ren;

   always #2.5 clk = ~clk;

   eeprom_page_writer #(
      .ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .LOAD_CYC(LC), .PROG_CYC(PC),
      .SYNC_STAGES(2), .MIN_LOW_CYC(2), .ERASE_VAL(8'hFF)
   ) i_eeprom_page_writer (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
   );

   function automatic logic [7:0] exp_status(input logic [7:0] last, input bit tbit);
      return {~last[7], tbit, 6'b0};
   endfunction

   function automatic logic [10:0] mk(input int pg, input int off);
      return {pg[4:0], off[5:0]};
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_load(input logic [10:0] a, input logic [7:0] d);
      if (!pany) begin
         ppage = a[10:6];
         pany  = 1'b1;
      end
      pv[a[5:0]] = 1'b1;
      pd[a[5:0]] = d;
      plast      = d;
   endtask

   task automatic model_commit();
      for (int i = 0; i < 64; i++) begin
         if (pv[i]) model[{ppage, i[5:0]}] = pd[i];
         pv[i] = 1'b0;
      end
      pany = 1'b0;
   endtask

   task automatic wr(input logic [10:0] a, input logic [7:0] d, input bit by_ce, input int low);
      addr = a; din = d; oe_n = 1'b1;
      if (by_ce) begin
         we_n = 1'b0; tick(1); ce_n = 1'b0; tick(low); ce_n = 1'b1; tick(1); we_n = 1'b1;
      end else begin
         ce_n = 1'b0; tick(1); we_n = 1'b0; tick(low); we_n = 1'b1; tick(1); ce_n = 1'b1;
      end
      tick(2);
   endtask

   task automatic rd(input logic [10:0] a);
      addr = a; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
      tick(5);
      rv = dout; ren = dout_en;
      ce_n = 1'b1; oe_n = 1'b1;
      tick(3);
   endtask

   task automatic rd_chk(input string req, input logic [10:0] a);
      rd(a);
      chk({req, " en"}, {7'b0, ren}, 8'h01);
      chk(req, rv, model[a]);
   endtask

   task automatic status_probe(input string req, input int wait_cyc, input int reads);
      tick(wait_cyc);
      for (int k = 0; k < reads; k++) begin
         rd(mk(0, 0));
         chk(req, rv, exp_status(plast, (k % 2) == 0));
      end
   endtask

   task automatic settle();
      tick(SETTLE);
      model_commit();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog all-R actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
      for (int i = 0; i < 64; i++) pv[i] = 1'b0;
      pany = 1'b0; plast = 8'h00;

      // R1 reset state
      tick(5);
      chk("R1 dout_en in reset", {7'b0, dout_en}, 8'h00);
      chk("R1 dout in reset", dout, 8'h00);
      rst_n = 1'b1;
      tick(5);
      chk("R1 dout_en after reset", {7'b0, dout_en}, 8'h00);
      rd_chk("R1 erased byte", mk(4, 35));

      // R2 mode decode for non-read combinations
      addr = mk(1, 1); ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; tick(5);
      chk("R2 ce high no drive", {7'b0, dout_en}, 8'h00);
      ce_n = 1'b0; oe_n = 1'b1; tick(5);
      chk("R2 oe/we high no drive", {7'b0, dout_en}, 8'h00);
      chk("R2 dout quiet", dout, 8'h00);
      ce_n = 1'b1; tick(3);

      // R3 write-enable strobe with output-enable low is not a write
      addr = mk(2, 9); din = 8'h3C; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; tick(5);
      chk("R2 both low no drive", {7'b0, dout_en}, 8'h00);
      we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b1; tick(3);
      tick(SETTLE);
      rd_chk("R3 oe low strobe ignored", mk(2, 9));

      // R4 write-enable steered, R12 early read, R10 status toggling, R9 commit
      wr(mk(1, 3), 8'hA5, 1'b0, 3); model_load(mk(1, 3), 8'hA5);
      rd_chk("R12 old data before programming", mk(1, 3));
      status_probe("R10 status", 30, 3);
      settle();
      rd_chk("R9 committed byte", mk(1, 3));
      rd_chk("R8 unloaded neighbour", mk(1, 4));

      // R4 chip-enable steered burst, R6 window restart across a long burst
      for (int i = 0; i < 5; i++) begin
         wr(mk(5, i), 8'h10 + 8'(i), 1'b1, 3); model_load(mk(5, i), 8'h10 + 8'(i));
         if (i == 3) begin
            rd(mk(5, 10));
            chk("R6 no programming while strobes keep coming", rv, 8'hFF);
            tick(4);
         end else begin
            tick(12);
         end
      end
      status_probe("R10 status ce burst", 30, 1);
      settle();
      for (int i = 0; i < 5; i++) rd_chk("R4 ce steered byte", mk(5, i));
      rd_chk("R8 offset outside burst", mk(5, 10));

      // R7 page taken from first byte, R8 overwrite
      wr(mk(7, 2), 8'h11, 1'b0, 3); model_load(mk(7, 2), 8'h11);
      wr(mk(9, 5), 8'h22, 1'b0, 3); model_load(mk(9, 5), 8'h22);
      wr(mk(7, 2), 8'h33, 1'b0, 3); model_load(mk(7, 2), 8'h33);
      status_probe("R10 status after overwrite", 30, 2);
      settle();
      rd_chk("R8 overwrite keeps last", mk(7, 2));
      rd_chk("R7 offset lands in first page", mk(7, 5));
      rd_chk("R7 other page untouched", mk(9, 5));

      // R5 minimum strobe width: 1 clock ignored, MIN_LOW_CYC accepted
      wr(mk(3, 0), 8'h5A, 1'b0, 1);
      rd(mk(3, 0));
      chk("R5 short strobe no programming", rv, 8'hFF);
      tick(SETTLE);
      rd_chk("R5 short strobe ignored", mk(3, 0));
      wr(mk(3, 1), 8'h6B, 1'b0, 2); model_load(mk(3, 1), 8'h6B);
      settle();
      rd_chk("R5 boundary strobe accepted", mk(3, 1));

      // R11 write during programming ignored
      wr(mk(12, 0), 8'h81, 1'b0, 3); model_load(mk(12, 0), 8'h81);
      tick(40);
      wr(mk(12, 1), 8'h19, 1'b0, 3);
      status_probe("R11 status unaffected by ignored write", 0, 1);
      settle();
      rd_chk("R11 first burst committed", mk(12, 0));
      rd_chk("R11 ignored byte not written", mk(12, 1));
      tick(SETTLE);
      rd_chk("R11 no later window from ignored write", mk(12, 1));

      // R8 full page of 64 bytes
      for (int i = 0; i < 64; i++) begin
         logic [7:0] d;
         d = 8'($urandom);
         wr(mk(20, i), d, i[0], 3); model_load(mk(20, i), d);
      end
      settle();
      for (int i = 0; i < 64; i++) rd_chk("R8 full page", mk(20, i));

      // random bursts
      for (int b = 0; b < 16; b++) begin
         int pg, n;
         int stray [0:5];
         pg = int'($urandom_range(0, 31));
         n  = int'($urandom_range(1, 6));
         for (int j = 0; j < n; j++) begin
            int off, wpg;
            logic [7:0] d;
            off = int'($urandom_range(0, 63));
            wpg = (j > 0 && $urandom_range(0, 3) == 0) ? int'($urandom_range(0, 31)) : pg;
            d   = 8'($urandom);
            stray[j] = int'(mk(wpg, off));
            wr(mk(wpg, off), d, 1'($urandom), 3);
            model_load(mk(wpg, off), d);
         end
         status_probe("R10 random status", 30, 1);
         settle();
         for (int i = 0; i < 64; i++) rd_chk("R7 R8 random page", mk(pg, i));
         for (int j = 0; j < n; j++) rd_chk("R7 random stray", 11'(stray[j]));
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule